// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a single-wire, shared, open-drain serial interrupt line. It runs the repeating cycle on that line. A cycle opens with a start pulse whose low time is programmable. Sixteen three-clock data slots follow, and in each one a device may pull the line low to report that its interrupt is asserted. A stop frame closes the cycle, and the stop frame's low width tells every agent which mode the next cycle uses. In continuous mode the host opens a new cycle as soon as a stop frame ends. In quiet mode the host leaves the line released until a device pulls it low for one clock, and then the host takes over that start pulse and finishes it.

The host samples each slot. At the end of the cycle it presents all sixteen levels together as an active-high interrupt vector. Slot 3 can also be routed to a separate system-management level. The line is brought out as an output-enable, an output value and the observed wire level, so an external open-drain pad can be placed around it.

Top module: `sirq_host_ctrl`

## Requirements
- R1: A start pulse stays low for W+1 clocks, where W is `cfg_start_width` with values 0, 1 and 2 treated as 3, so W is 3 to 7. When the host opens the cycle it drives every one of those clocks low, beginning one clock after it decides to start.
- R2: Right after the start pulse's low clocks, the host drives the line high for exactly one clock (clock 0 of the cycle). It then sets `sirq_oe` to 0 and keeps it at 0 through clock 49.
- R3: In continuous mode, the clock after a stop frame's high clock is the first low clock of a new start pulse. After reset the mode is continuous, so the host begins a start pulse in the second clock after reset is released.
- R4: In quiet mode the host never begins a cycle by itself. If the line is seen low for one clock while idle, the host drives it low for the next W clocks, so the whole pulse lasts W+1 clocks.
- R5: Slot N (1 to 16) is sampled at clock 3N-1 of the cycle. A low level reports the interrupt as asserted, and `irq_vec` bit N-1 is 1 when the slot was sampled low.
- R6: When `cfg_slot3_smi` is 1 at the vector update, slot 3 drives `smi_active` (1 when sampled low) and `irq_vec[2]` reads 0. When it is 0, slot 3 drives `irq_vec[2]` and `smi_active` reads 0.
- R7: The stop frame starts at clock 50. The host drives the line low for 2 clocks if quiet mode was requested, or for 3 clocks if continuous mode was requested. It then drives the line high for one clock and releases it, unless R3 applies.
- R8: `cfg_quiet_req` (1 = quiet) is taken only at the edge that ends clock 49. `mode_quiet` takes the new mode from the clock after the stop frame's high clock. A change of `cfg_quiet_req` at any other time has no effect on the line or on `mode_quiet` until that point.
- R9: `irq_vec` and `smi_active` change together, only at the edge that ends clock 49, and hold their values at all other times.
- R10: During reset `sirq_oe`, `irq_vec`, `smi_active` and `mode_quiet` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start_width | input | 3 | Extra start-pulse low clocks (3 to 7; lower values act as 3) |
| cfg_quiet_req | input | 1 | Mode requested for the next cycle: 1 = quiet, 0 = continuous |
| cfg_slot3_smi | input | 1 | 1 routes slot 3 to `smi_active` instead of `irq_vec[2]` |
| sirq_i | input | 1 | Observed level of the shared line |
| sirq_oe | output | 1 | Host drives the line when 1 |
| sirq_o | output | 1 | Level the host drives while `sirq_oe` is 1 |
| irq_vec | output | 16 | Decoded interrupt levels, bit N-1 for slot N, active high |
| smi_active | output | 1 | Decoded system-management level, active high |
| mode_quiet | output | 1 | Current mode: 1 = quiet, 0 = continuous |

## Verification
The line-drive outputs follow the controller state directly, so each drive level is due in the same clock the cycle position reaches. A sample taken in clock 3N-1 shows up in `irq_vec` only from clock 50, which is the first stop clock. `mode_quiet` changes one clock after the stop frame's high clock. The bench steps its own cycle-position model once per clock edge and compares every output at the falling edge that follows. Each comparison therefore falls inside the clock where the result is due, and never at the edge that produces it.

// File: rtl/sirq_host_pkg.sv
package sirq_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_START_LOW  = 3'd1,
        ST_START_HIGH = 3'd2,
        ST_DATA       = 3'd3,
        ST_STOP_LOW   = 3'd4,
        ST_STOP_HIGH  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/sirq_host_width_clamp.sv
module sirq_host_width_clamp #(
    parameter int WIDTH_BITS = 3,
    parameter int MIN_EXTRA  = 3
) (
    input  logic [WIDTH_BITS-1:0] raw_width,
    output logic [WIDTH_BITS-1:0] eff_width
);
    localparam logic [WIDTH_BITS-1:0] MIN_V = WIDTH_BITS'(MIN_EXTRA);

    always_comb begin
        if (raw_width < MIN_V) begin
            eff_width = MIN_V;
        end else begin
            eff_width = raw_width;
        end
    end
endmodule

// File: rtl/sirq_host_seq.sv
module sirq_host_seq
    import sirq_host_pkg::*;
#(
    parameter int NUM_SLOTS      = 16,
    parameter int SLOT_CLKS      = 3,
    parameter int WIDTH_BITS     = 3,
    parameter int MIN_EXTRA      = 3,
    parameter int STOP_LOW_QUIET = 2,
    parameter int STOP_LOW_CONT  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WIDTH_BITS-1:0]         start_extra,
    input  logic                          cfg_quiet_req,
    input  logic                          line_i,
    output logic                          drive_oe,
    output logic                          drive_val,
    output logic                          slot_strobe,
    output logic [$clog2(NUM_SLOTS)-1:0]  slot_idx,
    output logic                          cycle_end,
    output logic                          mode_quiet
);
    localparam int CNT_W     = WIDTH_BITS + 1;
    localparam int PH_W      = $clog2(SLOT_CLKS);
    localparam int DONE_W    = $clog2(NUM_SLOTS + 1);
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int MAX_EXTRA = (1 << WIDTH_BITS) - 1;

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [PH_W-1:0]    ph;
        logic [DONE_W-1:0]  done;
        logic               quiet;
        logic               next_quiet;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        drive_oe    = 1'b0;
        drive_val   = 1'b0;
        slot_strobe = 1'b0;
        cycle_end   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (!r_q.quiet) begin
                    r_d.st  = ST_START_LOW;
                    r_d.cnt = CNT_W'(start_extra);
                end else if (!line_i) begin
                    r_d.st  = ST_START_LOW;
                    r_d.cnt = CNT_W'(start_extra) - CNT_W'(1);
                end
            end
            ST_START_LOW: begin
                drive_oe = 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.st = ST_START_HIGH;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_START_HIGH: begin
                drive_oe  = 1'b1;
                drive_val = 1'b1;
                r_d.st    = ST_DATA;
                r_d.ph    = PH_W'(1);
                r_d.done  = '0;
            end
            ST_DATA: begin
                if (r_q.ph == PH_W'(SLOT_CLKS - 1)) begin
                    slot_strobe = 1'b1;
                    r_d.done    = r_q.done + DONE_W'(1);
                    r_d.ph      = '0;
                end else if (r_q.ph == PH_W'(SLOT_CLKS - 2) &&
                             r_q.done == DONE_W'(NUM_SLOTS)) begin
                    cycle_end      = 1'b1;
                    r_d.st         = ST_STOP_LOW;
                    r_d.next_quiet = cfg_quiet_req;
                    r_d.cnt        = cfg_quiet_req ? CNT_W'(STOP_LOW_QUIET - 1)
                                                   : CNT_W'(STOP_LOW_CONT - 1);
                end else begin
                    r_d.ph = r_q.ph + PH_W'(1);
                end
            end
            ST_STOP_LOW: begin
                drive_oe = 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.st = ST_STOP_HIGH;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_STOP_HIGH: begin
                drive_oe  = 1'b1;
                drive_val = 1'b1;
                r_d.quiet = r_q.next_quiet;
                if (r_q.next_quiet) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.st  = ST_START_LOW;
                    r_d.cnt = CNT_W'(start_extra);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st         <= ST_IDLE;
            r_q.cnt        <= '0;
            r_q.ph         <= '0;
            r_q.done       <= '0;
            r_q.quiet      <= 1'b0;
            r_q.next_quiet <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign slot_idx   = r_q.done[IDX_W-1:0];
    assign mode_quiet = r_q.quiet;

    // Checker state: consecutive clocks the host has held a start pulse low.
    logic [CNT_W:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (r_q.st == ST_START_LOW) begin
            low_run_q <= low_run_q + (CNT_W+1)'(1);
        end else begin
            low_run_q <= '0;
        end
    end

    p_start_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_START_LOW && r_q.cnt == '0) |->
            (int'(low_run_q) + 1 >= MIN_EXTRA && int'(low_run_q) + 1 <= MAX_EXTRA + 1));

    p_high_then_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_oe && drive_val && r_q.st == ST_START_HIGH) |=> !drive_oe);

    p_cont_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STOP_HIGH && !r_q.next_quiet) |=> (drive_oe && !drive_val));

    p_quiet_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && r_q.quiet && line_i) |=> (r_q.st == ST_IDLE && !drive_oe));

    p_mode_at_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_STOP_HIGH) |=> $stable(mode_quiet));
endmodule

// File: rtl/sirq_host_sampler.sv
module sirq_host_sampler #(
    parameter int NUM_SLOTS = 16,
    parameter int SMI_SLOT  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot_strobe,
    input  logic [$clog2(NUM_SLOTS)-1:0]  slot_idx,
    input  logic                          line_i,
    input  logic                          cycle_end,
    input  logic                          cfg_slot3_smi,
    output logic [NUM_SLOTS-1:0]          irq_vec,
    output logic                          smi_active
);
    localparam int SMI_BIT = SMI_SLOT - 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] shadow;
        logic [NUM_SLOTS-1:0] vec;
        logic                 smi;
    } samp_regs_t;

    samp_regs_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (slot_strobe) begin
            s_d.shadow[slot_idx] = line_i;
        end
        if (cycle_end) begin
            s_d.vec = ~s_q.shadow;
            s_d.smi = 1'b0;
            if (cfg_slot3_smi) begin
                s_d.smi          = ~s_q.shadow[SMI_BIT];
                s_d.vec[SMI_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shadow <= '1;
            s_q.vec    <= '0;
            s_q.smi    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_vec    = s_q.vec;
    assign smi_active = s_q.smi;

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_end |=> ($stable(irq_vec) && $stable(smi_active)));

    p_smi_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && !cfg_slot3_smi) |=> !smi_active);

    p_smi_bit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && cfg_slot3_smi) |=> !irq_vec[SMI_BIT]);
endmodule

// File: rtl/sirq_host_ctrl.sv
module sirq_host_ctrl #(
    parameter int NUM_SLOTS      = 16,
    parameter int SLOT_CLKS      = 3,
    parameter int WIDTH_BITS     = 3,
    parameter int MIN_EXTRA      = 3,
    parameter int SMI_SLOT       = 3,
    parameter int STOP_LOW_QUIET = 2,
    parameter int STOP_LOW_CONT  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH_BITS-1:0] cfg_start_width,
    input  logic                  cfg_quiet_req,
    input  logic                  cfg_slot3_smi,
    input  logic                  sirq_i,
    output logic                  sirq_oe,
    output logic                  sirq_o,
    output logic [NUM_SLOTS-1:0]  irq_vec,
    output logic                  smi_active,
    output logic                  mode_quiet
);
    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [WIDTH_BITS-1:0] start_extra;
    logic                  slot_strobe;
    logic [IDX_W-1:0]      slot_idx;
    logic                  cycle_end;

    sirq_host_width_clamp #(
        .WIDTH_BITS (WIDTH_BITS),
        .MIN_EXTRA  (MIN_EXTRA)
    ) u_clamp (
        .raw_width (cfg_start_width),
        .eff_width (start_extra)
    );

    sirq_host_seq #(
        .NUM_SLOTS      (NUM_SLOTS),
        .SLOT_CLKS      (SLOT_CLKS),
        .WIDTH_BITS     (WIDTH_BITS),
        .MIN_EXTRA      (MIN_EXTRA),
        .STOP_LOW_QUIET (STOP_LOW_QUIET),
        .STOP_LOW_CONT  (STOP_LOW_CONT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_extra   (start_extra),
        .cfg_quiet_req (cfg_quiet_req),
        .line_i        (sirq_i),
        .drive_oe      (sirq_oe),
        .drive_val     (sirq_o),
        .slot_strobe   (slot_strobe),
        .slot_idx      (slot_idx),
        .cycle_end     (cycle_end),
        .mode_quiet    (mode_quiet)
    );

    sirq_host_sampler #(
        .NUM_SLOTS (NUM_SLOTS),
        .SMI_SLOT  (SMI_SLOT)
    ) u_samp (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_strobe   (slot_strobe),
        .slot_idx      (slot_idx),
        .line_i        (sirq_i),
        .cycle_end     (cycle_end),
        .cfg_slot3_smi (cfg_slot3_smi),
        .irq_vec       (irq_vec),
        .smi_active    (smi_active)
    );
endmodule

// File: tb/sirq_host_ctrl_test.sv
`timescale 1ns/1ps
module sirq_host_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_start_width = 3'd0;
    logic        cfg_quiet_req = 1'b0;
    logic        cfg_slot3_smi = 1'b0;
    logic        dev_low = 1'b0;
    logic        sirq_oe, sirq_o, smi_active, mode_quiet;
    logic [15:0] irq_vec;
    logic        sirq_i;

    assign sirq_i = (sirq_oe ? sirq_o : 1'b1) & ~dev_low;

    always #2.5 clk = ~clk;

    sirq_host_ctrl uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_start_width (cfg_start_width), .cfg_quiet_req (cfg_quiet_req),
        .cfg_slot3_smi (cfg_slot3_smi), .sirq_i (sirq_i),
        .sirq_oe (sirq_oe), .sirq_o (sirq_o), .irq_vec (irq_vec),
        .smi_active (smi_active), .mode_quiet (mode_quiet)
    );

    localparam logic [15:0] QMASK = 16'b1001_0110_1011_0100;

    int n_checks = 0;
    int n_err = 0;

    // behavioural reference: 0 idle, 1 start low, 2 start high, 3 data, 4 stop low, 5 stop high
    int          m_st, m_prev, m_cnt, m_t, m_w, frame, idle_cnt;
    bit          m_quiet, m_nq;
    logic [15:0] m_shadow, e_vec, pat;
    bit          e_smi, e_oe, e_o, line_m;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat_of(input int f);
        if (f == 1) return 16'hFFFF;
        if (f == 2) return 16'h0000;
        return 16'(f * 40503) ^ 16'h5A3C;
    endfunction

    function automatic string drive_tag(input int st, input int prev, input bit q);
        case (st)
            0: return q ? "R4" : "R3";
            1: return (prev == 5) ? "R3" : "R1";
            2: return "R2";
            3: return "R2";
            default: return "R7";
        endcase
    endfunction

    initial begin
        m_st = 0; m_prev = 0; m_cnt = 0; m_t = 0; frame = 0; idle_cnt = 0;
        m_quiet = 0; m_nq = 0; m_shadow = 16'hFFFF; e_vec = 16'h0; e_smi = 0;
        repeat (4) @(negedge clk);
        chk(sirq_oe == 1'b0, "R10", "reset oe", {15'b0, sirq_oe}, 16'h0);
        chk(irq_vec == 16'h0, "R10", "reset vec", irq_vec, 16'h0);
        chk(smi_active == 1'b0, "R10", "reset smi", {15'b0, smi_active}, 16'h0);
        chk(mode_quiet == 1'b0, "R10", "reset mode", {15'b0, mode_quiet}, 16'h0);
        rst_n = 1'b1;
        for (int cyc = 0; frame < 16; cyc++) begin
            if (cyc > 6000) begin
                chk(1'b0, "R3", "watchdog expired", 16'(frame), 16'd16);
                break;
            end
            cfg_start_width = 3'(frame % 8);
            cfg_quiet_req   = QMASK[frame % 16];
            cfg_slot3_smi   = (frame % 3 == 0);
            pat             = pat_of(frame);

            e_oe = (m_st == 1 || m_st == 2 || m_st == 4 || m_st == 5);
            e_o  = (m_st == 2 || m_st == 5);
            chk(sirq_oe == e_oe, drive_tag(m_st, m_prev, m_quiet), "line enable",
                {15'b0, sirq_oe}, {15'b0, e_oe});
            if (e_oe)
                chk(sirq_o == e_o, drive_tag(m_st, m_prev, m_quiet), "line level",
                    {15'b0, sirq_o}, {15'b0, e_o});
            chk(irq_vec == e_vec, (m_prev == 3 && m_st == 4) ? "R5" : "R9", "vector",
                irq_vec, e_vec);
            chk(smi_active == e_smi, "R6", "smi level", {15'b0, smi_active}, {15'b0, e_smi});
            chk(mode_quiet == m_quiet, "R8", "mode", {15'b0, mode_quiet}, {15'b0, m_quiet});

            dev_low = 1'b0;
            if (m_st == 3 && m_t % 3 == 2 && pat[(m_t + 1) / 3 - 1]) dev_low = 1'b1;
            if (m_st == 0 && m_quiet && idle_cnt == 3 + frame % 4) dev_low = 1'b1;
            line_m = (e_oe ? e_o : 1'b1) & ~dev_low;

            m_w = (cfg_start_width < 3) ? 3 : int'(cfg_start_width);
            m_prev = m_st;
            case (m_st)
                0: begin
                    idle_cnt++;
                    if (!m_quiet) begin m_st = 1; m_cnt = m_w; end
                    else if (!line_m) begin m_st = 1; m_cnt = m_w - 1; end
                end
                1: if (m_cnt == 0) m_st = 2; else m_cnt--;
                2: begin m_st = 3; m_t = 1; end
                3: begin
                    if (m_t % 3 == 2) m_shadow[(m_t + 1) / 3 - 1] = line_m;
                    if (m_t == 49) begin
                        m_st = 4;
                        m_nq = cfg_quiet_req;
                        m_cnt = m_nq ? 1 : 2;
                        e_vec = ~m_shadow;
                        e_smi = 0;
                        if (cfg_slot3_smi) begin e_smi = ~m_shadow[2]; e_vec[2] = 1'b0; end
                        frame++;
                    end else m_t++;
                end
                4: if (m_cnt == 0) m_st = 5; else m_cnt--;
                default: begin
                    m_quiet = m_nq;
                    if (m_nq) begin m_st = 0; idle_cnt = 0; end
                    else begin m_st = 1; m_cnt = m_w; end
                end
            endcase
            @(negedge clk);
        end
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule